// File: doc/BRIEF.md
# Interrupt-Capable GPIO Port

An eight-pin general-purpose port with a small flat register interface. Each pin has its own output value, output enable and a selector that hands the pad to a peripheral instead of to software. Reads of the data register return the output value for driven pins and the synchronized pad level for pins that are inputs.

Every pin feeds an interrupt detector. The detector can be set per pin to edge or level sense, with a choice of polarity or of both edges. A raw status register records every detected condition, whether or not the pin is enabled. A mask register selects which raw bits reach the single combined interrupt line. A masked-in event on pin 4 also emits a one-cycle start pulse for an analog-to-digital converter.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, the direction, peripheral-select and enable registers read 0, `pin_oe` is 0 and `irq` is 0.
- R2: A pin whose peripheral-select bit is 1 takes `pin_out` and `pin_oe` from `alt_out` and `alt_oe`. A pin whose bit is 0 takes them from the data and direction registers.
- R3: Register offsets on `reg_addr` are 0x0 data, 0x1 direction, 0x2 peripheral select, 0x3 sense, 0x4 both-edges, 0x5 polarity, 0x6 enable, 0x7 raw status (read only), 0x8 gated status (read only) and 0x9 clear (write only). The clear offset and unused offsets read 0. Data reads give the data register on bits whose direction is 1 and the synchronized pad on bits whose direction is 0.
- R4: A detected condition sets its raw status bit whether or not the enable bit is 1. The bit is readable on the third rising edge after the pad changes, because the pad passes through a two-flop synchronizer and then an edge register.
- R5: With sense 0 the pin is edge-sensitive. A both-edges bit of 1 fires on either edge. Otherwise a polarity bit of 1 fires on rising edges and 0 on falling edges. Edge status stays set until it is cleared.
- R6: With sense 1 the pin is level-sensitive. Polarity 1 means high and 0 means low, and the raw bit follows the condition.
- R7: Writing 1 to a bit of the clear register clears that edge status bit, and writing 0 changes nothing. On a level pin the bit reasserts while the condition holds. A new edge in the same cycle as a clear leaves the bit set.
- R8: The gated status equals raw status AND enable. `irq` is the OR of the gated status bits.
- R9: `adc_trig` is high for exactly one cycle, in the cycle where gated status bit 4 rises. It stays low while enable bit 4 is 0.
- R10: A change to the sense, both-edges or polarity registers can raise a false interrupt on an enabled pin. For example, turning a low pin's level polarity from high to low sets its status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational on reg_addr) |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| alt_out | input | 8 | Peripheral output values |
| alt_oe | input | 8 | Peripheral output enables |
| alt_in | output | 8 | Synchronized pad levels to the peripheral |
| irq | output | 1 | Combined port interrupt |
| adc_trig | output | 1 | One-cycle converter start pulse |

## Verification
Two functions can meet in the same cycle: a software write of 1 to the clear register, and a fresh edge from the synchronizer on the same pin. The bench toggles a both-edges pin and times the clear write so that it commits on the edge where the new edge is registered. It then expects the raw bit to read 1, because setting must win over clearing. It also checks that the converter pulse and the port interrupt rise together, that the pulse falls one cycle later while the interrupt stays high, and that no pulse appears when pin 4 is masked.

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int W        = 8,
  parameter int AW       = 4,
  parameter int TRIG_BIT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe,
  input  logic [W-1:0]  alt_out,
  input  logic [W-1:0]  alt_oe,
  output logic [W-1:0]  alt_in,
  output logic          irq,
  output logic          adc_trig
);
  localparam logic [AW-1:0] A_DATA  = AW'(0);
  localparam logic [AW-1:0] A_DIR   = AW'(1);
  localparam logic [AW-1:0] A_ALT   = AW'(2);
  localparam logic [AW-1:0] A_SENSE = AW'(3);
  localparam logic [AW-1:0] A_BOTH  = AW'(4);
  localparam logic [AW-1:0] A_POL   = AW'(5);
  localparam logic [AW-1:0] A_EN    = AW'(6);
  localparam logic [AW-1:0] A_RAW   = AW'(7);
  localparam logic [AW-1:0] A_GATED = AW'(8);
  localparam logic [AW-1:0] A_CLR   = AW'(9);

  logic [W-1:0] data_q, dir_q, alt_q, sense_q, both_q, pol_q, en_q, raw_q;
  logic [W-1:0] sync1_q, sync2_q, prev_q;
  logic         gate_trig_q;

  logic [W-1:0] edge_hit, lvl_hit, clr_v, raw_n, gated;
  logic         wr_clr;

  assign wr_clr   = reg_wr && (reg_addr == A_CLR);
  assign clr_v    = wr_clr ? reg_wdata : '0;
  assign edge_hit = (both_q & (sync2_q ^ prev_q))
                  | (~both_q & ((pol_q & sync2_q & ~prev_q) | (~pol_q & ~sync2_q & prev_q)));
  assign lvl_hit  = (pol_q & sync2_q) | (~pol_q & ~sync2_q);
  assign raw_n    = (sense_q & lvl_hit) | (~sense_q & ((raw_q & ~clr_v) | edge_hit));
  assign gated    = raw_q & en_q;

  assign irq      = |gated;
  assign adc_trig = gated[TRIG_BIT] & ~gate_trig_q;
  assign alt_in   = sync2_q;
  assign pin_out  = (alt_q & alt_out) | (~alt_q & data_q);
  assign pin_oe   = (alt_q & alt_oe)  | (~alt_q & dir_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q     <= '0;
      sync2_q     <= '0;
      prev_q      <= '0;
      raw_q       <= '0;
      gate_trig_q <= 1'b0;
    end else begin
      sync1_q     <= pin_in;
      sync2_q     <= sync1_q;
      prev_q      <= sync2_q;
      raw_q       <= raw_n;
      gate_trig_q <= gated[TRIG_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      dir_q   <= '0;
      alt_q   <= '0;
      sense_q <= '0;
      both_q  <= '0;
      pol_q   <= '0;
      en_q    <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_DATA:  data_q  <= reg_wdata;
        A_DIR:   dir_q   <= reg_wdata;
        A_ALT:   alt_q   <= reg_wdata;
        A_SENSE: sense_q <= reg_wdata;
        A_BOTH:  both_q  <= reg_wdata;
        A_POL:   pol_q   <= reg_wdata;
        A_EN:    en_q    <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      A_DATA:  reg_rdata = (dir_q & data_q) | (~dir_q & sync2_q);
      A_DIR:   reg_rdata = dir_q;
      A_ALT:   reg_rdata = alt_q;
      A_SENSE: reg_rdata = sense_q;
      A_BOTH:  reg_rdata = both_q;
      A_POL:   reg_rdata = pol_q;
      A_EN:    reg_rdata = en_q;
      A_RAW:   reg_rdata = raw_q;
      A_GATED: reg_rdata = gated;
      default: reg_rdata = '0;
    endcase
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (dir_q == '0 && alt_q == '0 && en_q == '0));

  // R4
  raw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(edge_hit & ~sense_q)) |=>
      ((raw_q & $past(edge_hit & ~sense_q)) == $past(edge_hit & ~sense_q)));

  // R7
  clear_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && ((reg_wdata & (sense_q | edge_hit)) == '0)) |=>
      ((raw_q & $past(reg_wdata)) == '0));

  // R8
  no_enable_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);

  // R9
  trig_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_trig |=> !adc_trig);

  // R9
  trig_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_trig |-> (irq && en_q[TRIG_BIT]));
endmodule

// File: tb/gpio_irq_port_bench.sv
module gpio_irq_port_bench;
  localparam int K_RD = 0, K_IRQ = 1, K_TRIG = 2, K_OUT = 3, K_OE = 4;

  typedef struct {
    int         kind;
    logic [7:0] val;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [7:0] pin_in = 8'h30;
  logic [7:0] pin_out, pin_oe, alt_in;
  logic [7:0] alt_out = '0;
  logic [7:0] alt_oe = '0;
  logic       irq, adc_trig;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  item_t q[$];
  event go;

  always #5 clk = ~clk;

  gpio_irq_port u_gpio_irq_port (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .alt_out(alt_out), .alt_oe(alt_oe),
    .alt_in(alt_in), .irq(irq), .adc_trig(adc_trig)
  );

  initial begin : monitor
    forever begin
      @(go);
      begin
        item_t it;
        logic [7:0] act;
        it = q.pop_front();
        case (it.kind)
          K_RD:    act = reg_rdata;
          K_IRQ:   act = {7'd0, irq};
          K_TRIG:  act = {7'd0, adc_trig};
          K_OUT:   act = pin_out;
          default: act = pin_oe;
        endcase
        checks++;
        if (act !== it.val) begin
          fails++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.val);
        end
      end
    end
  end

  task automatic expect_v(int kind, logic [3:0] a, logic [7:0] v, string tag);
    item_t it;
    reg_addr = a;
    #1;
    it.kind = kind; it.val = v; it.tag = tag;
    q.push_back(it);
    -> go;
    #1;
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pin(logic [7:0] v);
    @(negedge clk);
    pin_in = v;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    idle(3);
    rst_n = 1'b1;
    idle(3);
    // R1 reset state
    expect_v(K_RD, 4'h1, 8'h00, "R1");
    expect_v(K_RD, 4'h2, 8'h00, "R1");
    expect_v(K_RD, 4'h6, 8'h00, "R1");
    expect_v(K_OE, 4'h0, 8'h00, "R1");
    expect_v(K_IRQ, 4'h0, 8'h00, "R1");

    // R3 register access and data read mix, R2 software path
    wr(4'h0, 8'hA5);
    wr(4'h1, 8'h0F);
    expect_v(K_RD, 4'h1, 8'h0F, "R3");
    expect_v(K_RD, 4'h0, 8'h35, "R3");
    expect_v(K_RD, 4'h9, 8'h00, "R3");
    expect_v(K_RD, 4'hF, 8'h00, "R3");
    expect_v(K_OUT, 4'h0, 8'hA5, "R2");
    expect_v(K_OE, 4'h0, 8'h0F, "R2");
    // R2 peripheral path
    alt_out = 8'h02; alt_oe = 8'h01;
    wr(4'h2, 8'h03);
    expect_v(K_OUT, 4'h0, 8'hA6, "R2");
    expect_v(K_OE, 4'h0, 8'h0D, "R2");
    wr(4'h2, 8'h00);
    wr(4'h1, 8'h00);

    // R7 clear-all after pins settle
    pin(8'h00);
    idle(4);
    wr(4'h9, 8'hFF);
    expect_v(K_RD, 4'h7, 8'h00, "R7");

    // R4 rising edge with pin disabled
    wr(4'h5, 8'h01);
    pin(8'h01);
    idle(3);
    expect_v(K_RD, 4'h7, 8'h01, "R4");
    expect_v(K_RD, 4'h8, 8'h00, "R8");
    expect_v(K_IRQ, 4'h0, 8'h00, "R8");
    pin(8'h00);
    idle(3);
    expect_v(K_RD, 4'h7, 8'h01, "R5");
    wr(4'h9, 8'h00);
    expect_v(K_RD, 4'h7, 8'h01, "R7");
    wr(4'h9, 8'h01);
    expect_v(K_RD, 4'h7, 8'h00, "R7");

    // R5 falling edge
    pin(8'h02);
    idle(3);
    expect_v(K_RD, 4'h7, 8'h00, "R5");
    pin(8'h00);
    idle(3);
    expect_v(K_RD, 4'h7, 8'h02, "R5");
    wr(4'h9, 8'hFF);

    // R5 both edges
    wr(4'h4, 8'h04);
    pin(8'h04);
    idle(3);
    expect_v(K_RD, 4'h7, 8'h04, "R5");
    wr(4'h9, 8'h04);
    pin(8'h00);
    idle(3);
    expect_v(K_RD, 4'h7, 8'h04, "R5");

    // R7 new edge in the same cycle as a clear: set wins
    pin(8'h04);
    idle(1);
    wr(4'h9, 8'h04);
    expect_v(K_RD, 4'h7, 8'h04, "R7");
    // R8 gated status and irq
    wr(4'h6, 8'h04);
    expect_v(K_RD, 4'h8, 8'h04, "R8");
    expect_v(K_IRQ, 4'h0, 8'h01, "R8");
    wr(4'h6, 8'h00);
    wr(4'h9, 8'hFF);
    expect_v(K_RD, 4'h7, 8'h00, "R7");

    // R6 level sense on pin 3
    wr(4'h5, 8'h09);
    wr(4'h3, 8'h08);
    idle(1);
    expect_v(K_RD, 4'h7, 8'h00, "R6");
    pin(8'h0C);
    idle(3);
    expect_v(K_RD, 4'h7, 8'h08, "R6");
    wr(4'h9, 8'h08);
    expect_v(K_RD, 4'h7, 8'h08, "R7");
    pin(8'h04);
    idle(3);
    expect_v(K_RD, 4'h7, 8'h00, "R6");

    // R10 false interrupt on polarity change
    wr(4'h6, 8'h08);
    expect_v(K_IRQ, 4'h0, 8'h00, "R10");
    wr(4'h5, 8'h01);
    idle(1);
    expect_v(K_IRQ, 4'h0, 8'h01, "R10");
    expect_v(K_RD, 4'h7, 8'h08, "R10");
    wr(4'h6, 8'h00);
    wr(4'h3, 8'h00);
    wr(4'h9, 8'hFF);
    expect_v(K_RD, 4'h7, 8'h00, "R7");

    // R9 converter trigger
    wr(4'h5, 8'h11);
    wr(4'h6, 8'h10);
    pin(8'h14);
    idle(3);
    expect_v(K_TRIG, 4'h0, 8'h01, "R9");
    expect_v(K_IRQ, 4'h0, 8'h01, "R9");
    idle(1);
    expect_v(K_TRIG, 4'h0, 8'h00, "R9");
    expect_v(K_IRQ, 4'h0, 8'h01, "R9");
    wr(4'h9, 8'h10);
    expect_v(K_IRQ, 4'h0, 8'h00, "R7");

    // R9 no trigger while pin 4 is masked
    wr(4'h6, 8'h00);
    pin(8'h04);
    idle(3);
    pin(8'h14);
    idle(2);
    expect_v(K_TRIG, 4'h0, 8'h00, "R9");
    idle(1);
    expect_v(K_TRIG, 4'h0, 8'h00, "R9");
    expect_v(K_RD, 4'h7, 8'h10, "R4");
    idle(1);
    expect_v(K_TRIG, 4'h0, 8'h00, "R9");

    idle(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule